// File: doc/BRIEF.md
# Multi-Centre Three-Step Motion Search Controller

This block runs a coarse-to-fine motion vector search that keeps three surviving centres at each refinement level instead of one. It sends candidate displacements to an external SAD engine, one request at a time, and reads back one SAD per candidate. The engine computes each SAD over alternate rows of the block, so a candidate costs half as much work. The controller keeps a ranked list of the lowest SADs it has seen. At the start of each finer level it takes the three best entries of that list as centres and searches around each of them with half the previous stride.

The first level issues the window centre and then the eight points at a distance of the initial stride (4). The next two levels issue eight neighbours around each of the three centres, with strides of 2 and then 1. A search therefore makes 9 + 3×8 + 3×8 = 57 requests. Positions that two centres share are issued twice, so the request count never varies. Each displacement component is clamped to the search window. When the last response arrives, the controller reports the lowest-SAD vector and its SAD together with a one-cycle done pulse.

Top module: `mcts_search`

## Requirements
- R1: After reset, `req_valid_o`, `done_o` and `busy_o` are low.
- R2: The first level issues (0,0) first. It then issues the eight neighbours at stride 4 in this fixed direction order, as (dx,dy) unit steps: (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1).
- R3: A search issues exactly 9 + 16×KEEP requests (57 with KEEP=3). The next request is not raised until the current one has had its response, so `req_valid_o` is low in the cycle after an accepted request.
- R4: Each finer level halves the stride (2, then 1). It visits the centres best-first. For each centre it issues that centre's eight neighbours in the R2 direction order.
- R5: The centres of a level are the KEEP lowest-SAD candidates among all responses received so far in the search. When two SADs are equal, the candidate that responded earlier ranks higher.
- R6: Each issued component is clamped to [-RANGE, +RANGE].
- R7: A position reached from two centres, or one that repeats an earlier candidate, is issued again and counts toward the R3 total.
- R8: After the last response, `done_o` is high for exactly one cycle. In that cycle `mv_dx_o`, `mv_dy_o` and `mv_sad_o` carry the lowest-SAD candidate, with ties ranked as in R5, and `busy_o` is low.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request stays raised and its displacement is held.
- R10: `start_i` has no effect while busy. `rsp_valid_i` has no effect unless a request has been accepted and its response is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (sampled while idle) |
| busy_o | output | 1 | A search is in progress |
| req_valid_o | output | 1 | Candidate request valid |
| req_ready_i | input | 1 | SAD engine accepts the request |
| req_dx_o | output | MV_W | Candidate horizontal displacement, signed |
| req_dy_o | output | MV_W | Candidate vertical displacement, signed |
| rsp_valid_i | input | 1 | SAD result valid |
| rsp_sad_i | input | SAD_W | Subsampled SAD of the pending candidate |
| done_o | output | 1 | One-cycle completion pulse |
| mv_dx_o | output | MV_W | Best horizontal displacement, signed |
| mv_dy_o | output | MV_W | Best vertical displacement, signed |
| mv_sad_o | output | SAD_W | SAD of the best displacement |

## Verification
The bench builds the controller with RANGE=5 and leaves the other parameters at their defaults (INIT_STEP=4, KEEP=3, MV_W=4, SAD_W=16). With the full window of 7, strides 4+2+1 can never leave the window, so the clamp would never be exercised. The narrower window lets second- and third-level neighbours of a corner centre cross the edge. A flat cost surface forces every tie and makes the three centres overlap, so duplicate positions get reissued.

// File: rtl/mcts_pkg.sv
package mcts_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_LATCH,
        S_FIN
    } ctl_state_e;

    // point 0 is the centre itself, points 1..8 are the eight neighbours
    function automatic int dir_x(logic [3:0] pt);
        case (pt)
            4'd1, 4'd4, 4'd6: dir_x = -1;
            4'd3, 4'd5, 4'd8: dir_x = 1;
            default:          dir_x = 0;
        endcase
    endfunction

    function automatic int dir_y(logic [3:0] pt);
        case (pt)
            4'd1, 4'd2, 4'd3: dir_y = -1;
            4'd6, 4'd7, 4'd8: dir_y = 1;
            default:          dir_y = 0;
        endcase
    endfunction

endpackage

// File: rtl/mcts_offset_gen.sv
module mcts_offset_gen import mcts_pkg::*; #(
    parameter int MV_W  = 4,
    parameter int RANGE = 7
) (
    input  logic signed [MV_W-1:0] cen_dx_i,
    input  logic signed [MV_W-1:0] cen_dy_i,
    input  logic        [3:0]      pt_i,
    input  logic        [MV_W-1:0] stride_i,
    output logic signed [MV_W-1:0] dx_o,
    output logic signed [MV_W-1:0] dy_o
);

    always_comb begin
        int sx;
        int sy;
        sx = int'(cen_dx_i) + dir_x(pt_i) * int'(stride_i);
        sy = int'(cen_dy_i) + dir_y(pt_i) * int'(stride_i);
        if (sx >  RANGE) sx =  RANGE;
        if (sx < -RANGE) sx = -RANGE;
        if (sy >  RANGE) sy =  RANGE;
        if (sy < -RANGE) sy = -RANGE;
        dx_o = MV_W'(sx);
        dy_o = MV_W'(sy);
    end

endmodule

// File: rtl/mcts_rank_keep.sv
module mcts_rank_keep #(
    parameter int KEEP  = 3,
    parameter int SAD_W = 16,
    parameter int MV_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       ins_i,
    input  logic [SAD_W-1:0]           sad_i,
    input  logic [MV_W-1:0]            dx_i,
    input  logic [MV_W-1:0]            dy_i,
    output logic [KEEP-1:0][MV_W-1:0]  dx_o,
    output logic [KEEP-1:0][MV_W-1:0]  dy_o,
    output logic [SAD_W-1:0]           best_sad_o
);

    typedef struct packed {
        logic             vld;
        logic [SAD_W-1:0] sad;
        logic [MV_W-1:0]  dx;
        logic [MV_W-1:0]  dy;
    } ent_t;

    typedef struct packed {
        ent_t [KEEP-1:0] e;
    } rank_t;

    rank_t rk_d, rk_q;
    logic [KEEP-1:0] beats;
    ent_t            fresh;

    assign fresh = '{vld: 1'b1, sad: sad_i, dx: dx_i, dy: dy_i};

    // strict comparison: an equal SAD stays behind the older entry
    for (genvar gi = 0; gi < KEEP; gi++) begin : g_cmp
        assign beats[gi] = !rk_q.e[gi].vld || (sad_i < rk_q.e[gi].sad);
        assign dx_o[gi]  = rk_q.e[gi].dx;
        assign dy_o[gi]  = rk_q.e[gi].dy;
    end

    assign best_sad_o = rk_q.e[0].sad;

    always_comb begin
        rk_d = rk_q;
        if (clr_i) begin
            for (int i = 0; i < KEEP; i++) rk_d.e[i].vld = 1'b0;
        end else if (ins_i) begin
            if (beats[0]) rk_d.e[0] = fresh;
            for (int i = 1; i < KEEP; i++) begin
                if (beats[i-1])   rk_d.e[i] = rk_q.e[i-1];
                else if (beats[i]) rk_d.e[i] = fresh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rk_q <= '0;
        else        rk_q <= rk_d;
    end

    for (genvar gi = 0; gi + 1 < KEEP; gi++) begin : g_sorted
        // R5
        ranked_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rk_q.e[gi+1].vld |-> (rk_q.e[gi].vld && rk_q.e[gi].sad <= rk_q.e[gi+1].sad));
    end

    // R5
    best_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_i && !clr_i) |=> (rk_q.e[0].vld && rk_q.e[0].sad <= $past(sad_i)));

endmodule

// File: rtl/mcts_search.sv
module mcts_search import mcts_pkg::*; #(
    parameter int SAD_W     = 16,
    parameter int MV_W      = 4,
    parameter int RANGE     = 7,
    parameter int INIT_STEP = 4,
    parameter int KEEP      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    output logic                    busy_o,
    output logic                    req_valid_o,
    input  logic                    req_ready_i,
    output logic signed [MV_W-1:0]  req_dx_o,
    output logic signed [MV_W-1:0]  req_dy_o,
    input  logic                    rsp_valid_i,
    input  logic [SAD_W-1:0]        rsp_sad_i,
    output logic                    done_o,
    output logic signed [MV_W-1:0]  mv_dx_o,
    output logic signed [MV_W-1:0]  mv_dy_o,
    output logic [SAD_W-1:0]        mv_sad_o
);

    localparam int NSTEPS = $clog2(INIT_STEP) + 1;
    localparam int STEP_W = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;
    localparam int CTR_W  = (KEEP > 1) ? $clog2(KEEP) : 1;

    typedef struct packed {
        ctl_state_e                state;
        logic [STEP_W-1:0]         step;
        logic [CTR_W-1:0]          ctr;
        logic [3:0]                pt;
        logic [KEEP-1:0][MV_W-1:0] cx;
        logic [KEEP-1:0][MV_W-1:0] cy;
        logic                      done;
        logic [MV_W-1:0]           mvx;
        logic [MV_W-1:0]           mvy;
        logic [SAD_W-1:0]          msad;
    } st_t;

    st_t st_d, st_q;

    logic                      clr, ins;
    logic [MV_W-1:0]           stride;
    logic [KEEP-1:0][MV_W-1:0] list_dx, list_dy;
    logic [SAD_W-1:0]          list_best;
    logic signed [MV_W-1:0]    off_dx, off_dy;
    logic                      last_pt, last_ctr, last_step;

    assign stride = MV_W'(INIT_STEP >> st_q.step);
    assign clr    = (st_q.state == S_IDLE) && start_i;
    assign ins    = (st_q.state == S_WAIT) && rsp_valid_i;

    mcts_offset_gen #(.MV_W(MV_W), .RANGE(RANGE)) i_offset (
        .cen_dx_i (st_q.cx[st_q.ctr]),
        .cen_dy_i (st_q.cy[st_q.ctr]),
        .pt_i     (st_q.pt),
        .stride_i (stride),
        .dx_o     (off_dx),
        .dy_o     (off_dy)
    );

    mcts_rank_keep #(.KEEP(KEEP), .SAD_W(SAD_W), .MV_W(MV_W)) i_rank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .ins_i      (ins),
        .sad_i      (rsp_sad_i),
        .dx_i       (off_dx),
        .dy_i       (off_dy),
        .dx_o       (list_dx),
        .dy_o       (list_dy),
        .best_sad_o (list_best)
    );

    assign last_pt   = (st_q.pt == 4'd8);
    assign last_ctr  = (st_q.step == '0) || (st_q.ctr == CTR_W'(KEEP - 1));
    assign last_step = (st_q.step == STEP_W'(NSTEPS - 1));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            S_IDLE: begin
                if (start_i) begin
                    st_d.state = S_REQ;
                    st_d.step  = '0;
                    st_d.ctr   = '0;
                    st_d.pt    = 4'd0;
                    st_d.cx    = '0;
                    st_d.cy    = '0;
                end
            end
            S_REQ: begin
                if (req_ready_i) st_d.state = S_WAIT;
            end
            S_WAIT: begin
                if (rsp_valid_i) begin
                    if (!last_pt) begin
                        st_d.pt    = st_q.pt + 4'd1;
                        st_d.state = S_REQ;
                    end else if (!last_ctr) begin
                        st_d.ctr   = st_q.ctr + 1'b1;
                        st_d.pt    = 4'd1;
                        st_d.state = S_REQ;
                    end else if (!last_step) begin
                        st_d.step  = st_q.step + 1'b1;
                        st_d.ctr   = '0;
                        st_d.pt    = 4'd1;
                        st_d.state = S_LATCH;
                    end else begin
                        st_d.state = S_FIN;
                    end
                end
            end
            S_LATCH: begin
                st_d.cx    = list_dx;
                st_d.cy    = list_dy;
                st_d.state = S_REQ;
            end
            S_FIN: begin
                st_d.done  = 1'b1;
                st_d.mvx   = list_dx[0];
                st_d.mvy   = list_dy[0];
                st_d.msad  = list_best;
                st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: S_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign busy_o      = (st_q.state != S_IDLE);
    assign req_valid_o = (st_q.state == S_REQ);
    assign req_dx_o    = off_dx;
    assign req_dy_o    = off_dy;
    assign done_o      = st_q.done;
    assign mv_dx_o     = st_q.mvx;
    assign mv_dy_o     = st_q.mvy;
    assign mv_sad_o    = st_q.msad;

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> !req_valid_o);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_dx_o) && $stable(req_dy_o)));

    // R6
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_dx_o <= RANGE && req_dx_o >= -RANGE &&
                         req_dy_o <= RANGE && req_dy_o >= -RANGE));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !req_valid_o));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

endmodule

// File: tb/test_mcts_search.sv
`timescale 1ns/100ps
module test_mcts_search;

    localparam int SAD_W = 16;
    localparam int MV_W  = 4;
    localparam int RG    = 5;
    localparam int NREQ  = 57;

    typedef struct packed {
        int tx; int ty; int wx; int wy; int base;
        bit stall; bit spur;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{tx:  3, ty: -2, wx: 1, wy: 1, base: 10,  stall: 1'b0, spur: 1'b0},
        '{tx:  7, ty:  7, wx: 2, wy: 3, base: 0,   stall: 1'b1, spur: 1'b0},
        '{tx: -6, ty:  1, wx: 5, wy: 1, base: 100, stall: 1'b1, spur: 1'b1},
        '{tx:  0, ty:  0, wx: 0, wy: 0, base: 42,  stall: 1'b0, spur: 1'b0},
        '{tx:  0, ty:  0, wx: 1, wy: 1, base: 0,   stall: 1'b0, spur: 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic req_ready_i = 1'b0;
    logic rsp_valid_i = 1'b0;
    logic [SAD_W-1:0] rsp_sad_i = '0;
    logic busy_o, req_valid_o, done_o;
    logic signed [MV_W-1:0] req_dx_o, req_dy_o, mv_dx_o, mv_dy_o;
    logic [SAD_W-1:0] mv_sad_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mcts_search #(.SAD_W(SAD_W), .MV_W(MV_W), .RANGE(RG), .INIT_STEP(4), .KEEP(3)) i_mcts_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_dx_o(req_dx_o), .req_dy_o(req_dy_o),
        .rsp_valid_i(rsp_valid_i), .rsp_sad_i(rsp_sad_i),
        .done_o(done_o), .mv_dx_o(mv_dx_o), .mv_dy_o(mv_dy_o), .mv_sad_o(mv_sad_o)
    );

    // reference model state, built from the requirements
    int exp_x [NREQ];
    int exp_y [NREQ];
    int got_x [NREQ];
    int got_y [NREQ];
    int lv [3]; int ls [3]; int lx [3]; int ly [3];
    int exp_bx, exp_by, exp_bs;

    function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction
    function automatic int clampw(int v);
        if (v > RG) return RG;
        if (v < -RG) return -RG;
        return v;
    endfunction
    // R2 direction order, k = 0..7
    function automatic int ux(int k);
        return (k == 0 || k == 3 || k == 5) ? -1 : ((k == 1 || k == 6) ? 0 : 1);
    endfunction
    function automatic int uy(int k);
        return (k < 3) ? -1 : ((k < 5) ? 0 : 1);
    endfunction
    function automatic int sad_of(int vi, int x, int y);
        return VECS[vi].base + VECS[vi].wx * iabs(x - VECS[vi].tx) + VECS[vi].wy * iabs(y - VECS[vi].ty);
    endfunction

    task automatic ref_insert(int s, int x, int y);
        int pos;
        pos = 3;
        for (int i = 2; i >= 0; i--) if (!lv[i] || s < ls[i]) pos = i;
        if (pos < 3) begin
            for (int i = 2; i > pos; i--) begin
                lv[i] = lv[i-1]; ls[i] = ls[i-1]; lx[i] = lx[i-1]; ly[i] = ly[i-1];
            end
            lv[pos] = 1; ls[pos] = s; lx[pos] = x; ly[pos] = y;
        end
    endtask

    task automatic ref_run(int vi);
        int n, st;
        int cxs [3]; int cys [3];
        n = 0;
        for (int i = 0; i < 3; i++) lv[i] = 0;
        exp_x[n] = 0; exp_y[n] = 0; ref_insert(sad_of(vi, 0, 0), 0, 0); n++;
        for (int k = 0; k < 8; k++) begin
            exp_x[n] = clampw(4 * ux(k)); exp_y[n] = clampw(4 * uy(k));
            ref_insert(sad_of(vi, exp_x[n], exp_y[n]), exp_x[n], exp_y[n]); n++;
        end
        st = 2;
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int c = 0; c < 3; c++) begin cxs[c] = lx[c]; cys[c] = ly[c]; end
            for (int c = 0; c < 3; c++) begin
                for (int k = 0; k < 8; k++) begin
                    exp_x[n] = clampw(cxs[c] + st * ux(k));
                    exp_y[n] = clampw(cys[c] + st * uy(k));
                    ref_insert(sad_of(vi, exp_x[n], exp_y[n]), exp_x[n], exp_y[n]); n++;
                end
            end
            st = st / 2;
        end
        exp_bx = lx[0]; exp_by = ly[0]; exp_bs = ls[0];
    endtask

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic run_vec(int vi);
        int nreq, extra, waitc, dpos, dup, maxabs;
        bit hold_ok, single_ok, got_done, pulse_ok;
        int gbx, gby, gbs;
        ref_run(vi);
        nreq = 0; extra = 0; hold_ok = 1; single_ok = 1; got_done = 0; pulse_ok = 1;
        gbx = 0; gby = 0; gbs = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int n = 0; n < NREQ; n++) begin
            waitc = 0;
            while (!req_valid_o && waitc < 40) begin @(negedge clk); waitc++; end
            if (!req_valid_o) break;
            got_x[n] = int'(req_dx_o); got_y[n] = int'(req_dy_o); nreq++;
            if (VECS[vi].stall) begin
                for (int s = 0; s < 2; s++) begin
                    if (VECS[vi].spur && n == 5 && s == 0) begin
                        rsp_valid_i = 1'b1; rsp_sad_i = '0; start_i = 1'b1;
                    end
                    @(negedge clk);
                    rsp_valid_i = 1'b0; start_i = 1'b0;
                    if (!req_valid_o || int'(req_dx_o) != got_x[n] || int'(req_dy_o) != got_y[n])
                        hold_ok = 0;
                end
            end else if (VECS[vi].spur && n == 7) begin
                rsp_valid_i = 1'b1; rsp_sad_i = '0; start_i = 1'b1;
                @(negedge clk);
                rsp_valid_i = 1'b0; start_i = 1'b0;
            end
            req_ready_i = 1'b1;
            @(negedge clk); req_ready_i = 1'b0;
            if (req_valid_o) single_ok = 0;
            rsp_valid_i = 1'b1; rsp_sad_i = SAD_W'(sad_of(vi, got_x[n], got_y[n]));
            @(negedge clk); rsp_valid_i = 1'b0;
        end
        for (int c = 0; c < 10 && !got_done; c++) begin
            if (done_o) begin
                got_done = 1;
                gbx = int'(mv_dx_o); gby = int'(mv_dy_o); gbs = int'(mv_sad_o);
                if (busy_o) pulse_ok = 0;
            end else begin
                if (req_valid_o) extra++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        if (done_o) pulse_ok = 0;
        for (int c = 0; c < 5; c++) begin
            if (req_valid_o) extra++;
            @(negedge clk);
        end

        dpos = -1;
        for (int n = 0; n < 9 && n < nreq; n++)
            if (dpos < 0 && (got_x[n] != exp_x[n] || got_y[n] != exp_y[n])) dpos = n;
        check(dpos < 0, $sformatf("R2 vec%0d step0 offset at idx", vi), dpos, -1);
        dpos = -1;
        for (int n = 9; n < nreq; n++)
            if (dpos < 0 && (got_x[n] != exp_x[n] || got_y[n] != exp_y[n])) dpos = n;
        check(dpos < 0, $sformatf("R4 R5 vec%0d finer offset at idx", vi), dpos, -1);
        check(nreq == NREQ && extra == 0, $sformatf("R3 vec%0d request count", vi), nreq + extra, NREQ);
        check(single_ok, $sformatf("R3 vec%0d req_valid after accept", vi), int'(single_ok), 1);
        if (VECS[vi].stall)
            check(hold_ok, $sformatf("R9 vec%0d held during stall", vi), int'(hold_ok), 1);
        check(got_done && pulse_ok, $sformatf("R8 vec%0d one-cycle done, busy low", vi),
              int'(got_done && pulse_ok), 1);
        check(gbx == exp_bx && gby == exp_by,
              $sformatf("R8 R10 vec%0d best vector (x*16+y)", vi), gbx * 16 + gby, exp_bx * 16 + exp_by);
        check(gbs == exp_bs, $sformatf("R8 R10 vec%0d best SAD", vi), gbs, exp_bs);
        if (vi == 1) begin
            maxabs = 0;
            for (int n = 0; n < nreq; n++) begin
                if (iabs(got_x[n]) > maxabs) maxabs = iabs(got_x[n]);
                if (iabs(got_y[n]) > maxabs) maxabs = iabs(got_y[n]);
            end
            check(maxabs == RG, "R6 clamp reaches window edge", maxabs, RG);
        end
        if (vi == 3) begin
            dup = 0;
            for (int a = 0; a < nreq; a++)
                for (int b = a + 1; b < nreq; b++)
                    if (got_x[a] == got_x[b] && got_y[a] == got_y[b]) dup++;
            check(dup > 0 && nreq == NREQ, "R7 duplicates reissued", dup, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!req_valid_o, "R1 req_valid in reset", int'(req_valid_o), 0);
        check(!done_o && !busy_o, "R1 done/busy in reset", int'(done_o) + int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !req_valid_o, "R1 idle after reset", int'(busy_o), 0);
        for (int vi = 0; vi < NV; vi++) run_vec(vi);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule